// File: doc/BRIEF.md
# Duty-Cycled Wake-Up Receiver Power Sequencer

This block sits in the back-end of a wake-up receiver and decides when the analog front-end and its digitizer are powered. Most of the time it sleeps: a down-counter runs out a programmable sleep period, which sets the worst-case wake-up latency. When that period ends, the block raises the front-end power enable and holds off the preamble detector for a settle time while supplies and oscillators stabilise. It then enables the detector for a polling interval. The listen window is therefore the settle time plus one preamble-edge timeout.

If the detector reports no preamble before the window closes, power is removed and a new sleep period begins. If a preamble is reported, the block keeps the front-end powered for as long as the address decoder is working. Power is dropped only when the decoder signals done or abort, so the active time grows only with the number of preambles actually seen. All durations are counted in cycles of the one clock. With a 1 MHz clock, the default settings give a 32 ms sleep and a 13 µs window (5 settle plus 8 polling).

Top module: `rx_duty_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the block in the sleep phase with every output low and the configuration at its defaults (sleep 32000, settle 5, polling 8 cycles).
- R2: The sleep phase lasts exactly the configured number of sleep cycles. The power enable then rises.
- R3: After sleep, the power enable is high with the detector enable low for exactly the settle count. The detector enable is then high for up to the polling count, and it is only ever high while power is high.
- R4: If no preamble is reported during the polling cycles, power and detector enable drop together after the last polling cycle, and a full sleep period follows.
- R5: A preamble report in any polling cycle moves the block to the decode phase in the next cycle. Power stays high with the detector enable low until a decode-done or decode-abort input is seen. The block then returns to sleep.
- R6: A preamble report outside the polling phase, and decode-done or decode-abort outside the decode phase, have no effect.
- R7: The configuration load strobe is accepted only in sleep-phase cycles and is ignored in every other phase. An accepted load governs every phase that begins after the load cycle. The sleep period already running is not cut short or stretched.
- R8: A configured length of zero is treated as one cycle.
- R9: The state port reports sleep as 0, settle as 1, polling as 2 and decode as 3.
- R10: The sleep-start output is a one-cycle pulse in the first cycle of each return to sleep. It stays low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration load strobe, honoured in sleep only |
| cfg_sleep | input | SLEEP_W | Sleep period in cycles |
| cfg_settle | input | SETTLE_W | Front-end settle time in cycles |
| cfg_poll | input | POLL_W | Preamble polling interval in cycles |
| pre_found | input | 1 | Valid preamble reported by the detector |
| dec_done | input | 1 | Address decoder finished |
| dec_abort | input | 1 | Address decoder gave up |
| fe_power_en | output | 1 | Power enable for the front-end and digitizer |
| det_enable | output | 1 | Preamble detector enable (polling phase) |
| seq_state | output | 2 | Current phase code |
| sleep_start | output | 1 | One-cycle pulse on each return to sleep |

## Verification
The hardest case to reach is a configuration load in the very last sleep cycle. In that cycle the sequencer is already choosing the settle length, so the new value has to be forwarded in the same cycle. A load in any earlier sleep cycle would hide a missing bypass. The bench sweeps small sleep, settle and polling lengths and places the load on the final sleep cycle for half of the configurations. It also places preamble reports on the first and last polling cycles, and drives stray preamble and decoder strobes in the phases where they must be ignored.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LISTEN = 2'd2,
    ST_DECODE = 2'd3
  } seq_state_t;

endpackage

// File: rtl/rxseq_cfg.sv
module rxseq_cfg #(
  parameter int SLEEP_W    = 24,
  parameter int SETTLE_W   = 8,
  parameter int POLL_W     = 8,
  parameter int DEF_SLEEP  = 32000,
  parameter int DEF_SETTLE = 5,
  parameter int DEF_POLL   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idle,
  input  logic                load,
  input  logic [SLEEP_W-1:0]  in_sleep,
  input  logic [SETTLE_W-1:0] in_settle,
  input  logic [POLL_W-1:0]   in_poll,
  output logic [SLEEP_W-1:0]  eff_sleep,
  output logic [SETTLE_W-1:0] eff_settle,
  output logic [POLL_W-1:0]   eff_poll
);

  localparam logic [SLEEP_W-1:0]  RST_SLEEP  = SLEEP_W'(DEF_SLEEP);
  localparam logic [SETTLE_W-1:0] RST_SETTLE = SETTLE_W'(DEF_SETTLE);
  localparam logic [POLL_W-1:0]   RST_POLL   = POLL_W'(DEF_POLL);

  logic [SLEEP_W-1:0]  sleep_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [POLL_W-1:0]   poll_q;
  logic [SLEEP_W-1:0]  sleep_c;
  logic [SETTLE_W-1:0] settle_c;
  logic [POLL_W-1:0]   poll_c;
  logic                accept;

  assign accept = load & idle & ~rst;

  // zero-length requests are stretched to a single cycle
  always_comb begin
    sleep_c  = (in_sleep  == '0) ? SLEEP_W'(1)  : in_sleep;
    settle_c = (in_settle == '0) ? SETTLE_W'(1) : in_settle;
    poll_c   = (in_poll   == '0) ? POLL_W'(1)   : in_poll;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q  <= (RST_SLEEP  == '0) ? SLEEP_W'(1)  : RST_SLEEP;
      settle_q <= (RST_SETTLE == '0) ? SETTLE_W'(1) : RST_SETTLE;
      poll_q   <= (RST_POLL   == '0) ? POLL_W'(1)   : RST_POLL;
    end else if (accept) begin
      sleep_q  <= sleep_c;
      settle_q <= settle_c;
      poll_q   <= poll_c;
    end
  end

  // forward a load in the same cycle so a phase starting next cycle sees it
  always_comb begin
    eff_sleep  = accept ? sleep_c  : sleep_q;
    eff_settle = accept ? settle_c : settle_q;
    eff_poll   = accept ? poll_c   : poll_q;
  end

  a_r7_busy_load_ignored: assert property (@(posedge clk) disable iff (rst)
    (load && !idle) |=> ($stable(sleep_q) && $stable(settle_q) && $stable(poll_q)));

  a_r8_regs_nonzero: assert property (@(posedge clk) disable iff (rst)
    accept |=> (sleep_q != '0 && settle_q != '0 && poll_q != '0));

endmodule

// File: rtl/rxseq_timer.sv
module rxseq_timer #(
  parameter int W       = 24,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == W'(1));

  a_r2_counts_down: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r5_idle_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
  import rxseq_pkg::*;
#(
  parameter int SLEEP_W  = 24,
  parameter int SETTLE_W = 8,
  parameter int POLL_W   = 8,
  parameter int CNT_W    = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tmr_last,
  input  logic                pre_found,
  input  logic                dec_done,
  input  logic                dec_abort,
  input  logic [SLEEP_W-1:0]  eff_sleep,
  input  logic [SETTLE_W-1:0] eff_settle,
  input  logic [POLL_W-1:0]   eff_poll,
  output logic                tmr_load,
  output logic [CNT_W-1:0]    tmr_val,
  output logic                idle,
  output seq_state_t          state_q,
  output logic                fe_power_en,
  output logic                det_enable,
  output logic                sleep_start
);

  seq_state_t nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_SLEEP:  if (tmr_last) nxt = ST_SETTLE;
      ST_SETTLE: if (tmr_last) nxt = ST_LISTEN;
      ST_LISTEN: begin
        if (pre_found)     nxt = ST_DECODE;
        else if (tmr_last) nxt = ST_SLEEP;
      end
      ST_DECODE: if (dec_done || dec_abort) nxt = ST_SLEEP;
      default:   nxt = ST_SLEEP;
    endcase
  end

  // the timer is reloaded with the length of the phase being entered
  always_comb begin
    tmr_load = (nxt != state_q);
    unique case (nxt)
      ST_SLEEP:  tmr_val = CNT_W'(eff_sleep);
      ST_SETTLE: tmr_val = CNT_W'(eff_settle);
      ST_LISTEN: tmr_val = CNT_W'(eff_poll);
      default:   tmr_val = '0;
    endcase
  end

  assign idle = (state_q == ST_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SLEEP;
      fe_power_en <= 1'b0;
      det_enable  <= 1'b0;
      sleep_start <= 1'b0;
    end else begin
      state_q     <= nxt;
      fe_power_en <= (nxt != ST_SLEEP);
      det_enable  <= (nxt == ST_LISTEN);
      sleep_start <= (nxt == ST_SLEEP) && (state_q != ST_SLEEP);
    end
  end

  a_r5_decode_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && !dec_done && !dec_abort) |=>
      (state_q == ST_DECODE && fe_power_en && !det_enable));

  a_r5_decode_exit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && (dec_done || dec_abort)) |=>
      (state_q == ST_SLEEP && !fe_power_en && sleep_start));

  a_r4_window_close: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LISTEN && tmr_last && !pre_found) |=>
      (state_q == ST_SLEEP && !fe_power_en && !det_enable));

  a_r6_stray_preamble: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE || state_q == ST_SLEEP) |=> (state_q != ST_DECODE));

  a_r3_detector_powered: assert property (@(posedge clk) disable iff (rst)
    det_enable |-> fe_power_en);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sleep_start |=> !sleep_start);

endmodule

// File: rtl/rx_duty_sequencer.sv
module rx_duty_sequencer
  import rxseq_pkg::*;
#(
  parameter int SLEEP_W    = 24,
  parameter int SETTLE_W   = 8,
  parameter int POLL_W     = 8,
  parameter int DEF_SLEEP  = 32000,
  parameter int DEF_SETTLE = 5,
  parameter int DEF_POLL   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_load,
  input  logic [SLEEP_W-1:0]  cfg_sleep,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [POLL_W-1:0]   cfg_poll,
  input  logic                pre_found,
  input  logic                dec_done,
  input  logic                dec_abort,
  output logic                fe_power_en,
  output logic                det_enable,
  output logic [1:0]          seq_state,
  output logic                sleep_start
);

  localparam int W_A   = (SLEEP_W > SETTLE_W) ? SLEEP_W : SETTLE_W;
  localparam int CNT_W = (W_A > POLL_W) ? W_A : POLL_W;
  localparam int TMR_RST = (DEF_SLEEP == 0) ? 1 : DEF_SLEEP;

  logic [SLEEP_W-1:0]  eff_sleep;
  logic [SETTLE_W-1:0] eff_settle;
  logic [POLL_W-1:0]   eff_poll;
  logic                idle;
  logic                tmr_load;
  logic                tmr_last;
  logic [CNT_W-1:0]    tmr_val;
  seq_state_t          state_q;

  rxseq_cfg #(
    .SLEEP_W(SLEEP_W), .SETTLE_W(SETTLE_W), .POLL_W(POLL_W),
    .DEF_SLEEP(DEF_SLEEP), .DEF_SETTLE(DEF_SETTLE), .DEF_POLL(DEF_POLL)
  ) u_cfg (
    .clk(clk), .rst(rst), .idle(idle), .load(cfg_load),
    .in_sleep(cfg_sleep), .in_settle(cfg_settle), .in_poll(cfg_poll),
    .eff_sleep(eff_sleep), .eff_settle(eff_settle), .eff_poll(eff_poll)
  );

  rxseq_timer #(.W(CNT_W), .RST_VAL(TMR_RST)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  rxseq_fsm #(
    .SLEEP_W(SLEEP_W), .SETTLE_W(SETTLE_W), .POLL_W(POLL_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .tmr_last(tmr_last),
    .pre_found(pre_found), .dec_done(dec_done), .dec_abort(dec_abort),
    .eff_sleep(eff_sleep), .eff_settle(eff_settle), .eff_poll(eff_poll),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .idle(idle), .state_q(state_q),
    .fe_power_en(fe_power_en), .det_enable(det_enable), .sleep_start(sleep_start)
  );

  assign seq_state = state_q;

endmodule

// File: tb/tb_rx_duty_sequencer.sv
module tb_rx_duty_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int SLEEP_W = 24;
  localparam int SETTLE_W = 8;
  localparam int POLL_W = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [SLEEP_W-1:0]  cfg_sleep = '0;
  logic [SETTLE_W-1:0] cfg_settle = '0;
  logic [POLL_W-1:0]   cfg_poll = '0;
  logic pre_found = 1'b0, dec_done = 1'b0, dec_abort = 1'b0;
  logic fe_power_en, det_enable, sleep_start;
  logic [1:0] seq_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int exp_S = 32000;
  int exp_E = 5;
  int exp_L = 8;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_duty_sequencer dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_sleep(cfg_sleep),
    .cfg_settle(cfg_settle), .cfg_poll(cfg_poll), .pre_found(pre_found),
    .dec_done(dec_done), .dec_abort(dec_abort), .fe_power_en(fe_power_en),
    .det_enable(det_enable), .seq_state(seq_state), .sleep_start(sleep_start)
  );

  function automatic int clampv(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(string tag, logic [1:0] st, bit pw, bit de, bit ss);
    n_cmp++;
    if (seq_state !== st || fe_power_en !== pw || det_enable !== de || sleep_start !== ss) begin
      n_bad++;
      $display("FAIL %s R9: got state=%0d pwr=%0b det=%0b start=%0b, expected state=%0d pwr=%0b det=%0b start=%0b",
               tag, seq_state, fe_power_en, det_enable, sleep_start, st, pw, de, ss);
    end
  endtask

  // One full sleep/settle/poll(/decode) cycle, checked at every negedge.
  task automatic period(string tag, bit first, int pre_idx, int dec_len, bit use_abort,
                        bit noise, int load_idx, int nS, int nE, int nL, bit busy_load);
    int s;
    bit go;
    s = exp_S;
    go = 1'b0;
    for (int i = 0; i < s; i++) begin
      chk($sformatf("%s R2 R10 sleep[%0d]", tag, i), 2'd0, 1'b0, 1'b0, (i == 0) && !first);
      pre_found = noise; dec_done = noise; dec_abort = noise;
      cfg_load = (i == load_idx);
      cfg_sleep = SLEEP_W'(nS); cfg_settle = SETTLE_W'(nE); cfg_poll = POLL_W'(nL);
      if (i == load_idx) begin
        exp_S = clampv(nS); exp_E = clampv(nE); exp_L = clampv(nL);
      end
      @(negedge clk);
    end
    for (int i = 0; i < exp_E; i++) begin
      chk($sformatf("%s R3 settle[%0d]", tag, i), 2'd1, 1'b1, 1'b0, 1'b0);
      pre_found = noise; dec_done = noise; dec_abort = noise;
      cfg_load = busy_load;
      cfg_sleep = SLEEP_W'(7); cfg_settle = SETTLE_W'(7); cfg_poll = POLL_W'(7);
      @(negedge clk);
    end
    for (int i = 0; i < exp_L; i++) begin
      chk($sformatf("%s R3 R4 poll[%0d]", tag, i), 2'd2, 1'b1, 1'b1, 1'b0);
      pre_found = (i == pre_idx); dec_done = noise; dec_abort = noise;
      cfg_load = busy_load;
      @(negedge clk);
      if (i == pre_idx) begin
        go = 1'b1;
        break;
      end
    end
    if (go) begin
      for (int j = 0; j < dec_len; j++) begin
        chk($sformatf("%s R5 decode[%0d]", tag, j), 2'd3, 1'b1, 1'b0, 1'b0);
        pre_found = noise; cfg_load = busy_load;
        dec_done  = (j == dec_len - 1) && !use_abort;
        dec_abort = (j == dec_len - 1) && use_abort;
        @(negedge clk);
      end
    end
    pre_found = 1'b0; dec_done = 1'b0; dec_abort = 1'b0; cfg_load = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog: run still active after %0d cycles, expected completion earlier", WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 2'd0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    // defaults: 32000 sleep, 5 settle, 8 polling, no preamble
    period("R1 defaults", 1'b1, -1, 1, 1'b0, 1'b0, -1, 0, 0, 0, 1'b0);
    // load on the final sleep cycle must govern the settle that follows
    period("R7 last-cycle load", 1'b0, -1, 1, 1'b0, 1'b0, exp_S - 1, 2, 1, 2, 1'b0);
    for (int s = 1; s <= 3; s++)
      for (int e = 1; e <= 2; e++)
        for (int l = 1; l <= 3; l++) begin
          period("R7 sweep load", 1'b0, -1, 1, 1'b0, 1'b0,
                 (e == 1) ? 0 : exp_S - 1, s, e, l, 1'b0);
          for (int pm = 0; pm < 3; pm++) begin
            int pidx;
            pidx = (pm == 0) ? -1 : ((pm == 1) ? 0 : l - 1);
            period((pm == 0) ? "R4 sweep" : ((pm == 1) ? "R5 R6 sweep" : "R5 sweep"),
                   1'b0, pidx, 1 + pm, pm[0], pm == 1, -1, 0, 0, 0, 1'b0);
          end
        end
    // loads outside sleep are ignored; lengths stay 3/2/3
    period("R7 busy load", 1'b0, 0, 3, 1'b1, 1'b0, -1, 0, 0, 0, 1'b1);
    period("R7 after busy", 1'b0, -1, 1, 1'b0, 1'b0, -1, 0, 0, 0, 1'b0);
    // zero lengths behave as one cycle
    period("R8 zero load", 1'b0, -1, 1, 1'b0, 1'b0, 0, 0, 0, 0, 1'b0);
    period("R8 zero lengths", 1'b0, -1, 1, 1'b0, 1'b1, -1, 0, 0, 0, 1'b0);
    period("R8 zero with preamble", 1'b0, 0, 2, 1'b0, 1'b1, -1, 0, 0, 0, 1'b0);
    chk("R10 final sleep", 2'd0, 1'b0, 1'b0, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule